// File: doc/BRIEF.md
# Slave-Side Bus Mastership Requester

This block sits on the slave processor's side of a shared external local bus. Before every internal access it wins the bus from an external master. It lowers an active-low request line and waits for the master's active-low grant. It then moves the shared bus control signals from high impedance to actively driven and hands the cycle to an attached bus-cycle engine. When the engine is done, it hands the bus back. Out of reset the bus is released. The first internal access after reset, which is the reset-vector fetch, starts the first arbitration.

The grant is sampled only on rising clock edges. A run of at least `MIN_GRANT` consecutive asserted samples is needed before the block commits to the bus. A shorter run restarts the count and leaves the request low. From the first sample of a qualifying run, the control outputs are driven at their inactive level `DRIVE_DELAY` edges later. After one such cycle, the engine's access cycle starts. When the engine reports completion, the request is raised on that same edge while the controls stay at their inactive level. One edge later the controls float. Each internal access runs through the whole sequence, and mastership is never kept from one access to the next.

The internal side is a level request that is held until a one-cycle done pulse. The request carries address, write data and direction. The engine side is a one-cycle start pulse with captured address, data and direction, followed by a done pulse that carries read data.

Top module: `slave_bus_requester`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bus_req_n_o` is 1, `bus_oe_o` is 0 (controls in high impedance), and `bus_own_o`, `eng_start_o` and `acc_done_o` are 0.
- R2: An `acc_req_i` sampled at a rising edge while the block is idle drives `bus_req_n_o` to 0 after that edge. The same edge captures `acc_addr_i`, `acc_wdata_i` and `acc_we_i`.
- R3: While requesting, `bus_gnt_n_i` counts only as rising-edge samples, where 0 means granted. A run of fewer than `MIN_GRANT` (default 2) consecutive granted samples restarts the count, keeps `bus_req_n_o` at 0 and leaves `bus_oe_o` at 0.
- R4: If the grant stays at 0 on every sample from the first one of a run up to and including the edge `DRIVE_DELAY` (default 2) edges later, `bus_oe_o` becomes 1 after that later edge, with `bus_own_o` at 0. A grant of 1 at any edge before that returns the block to requesting with a fresh count.
- R5: After exactly one cycle with `bus_oe_o`=1 and `bus_own_o`=0, `bus_own_o` becomes 1. `eng_start_o` pulses for that first cycle only, with `eng_addr_o`, `eng_wdata_o` and `eng_we_o` equal to the captured request.
- R6: `eng_done_i` sampled at 1 during the access makes `bus_req_n_o` 1 after that edge. `bus_oe_o` stays 1 and `bus_own_o` goes to 0 for that one cycle. `acc_done_o` pulses in the same cycle, and for a read (`acc_we_i`=0) `acc_rdata_o` carries the sampled `eng_rdata_i`.
- R7: On the edge after the request is raised, `bus_oe_o` returns to 0.
- R8: Back-to-back internal requests each produce their own low period of `bus_req_n_o` and their own grant qualification. `bus_req_n_o` stays high for at least two cycles between accesses.
- R9: While the block is not requesting, a grant of 0 on `bus_gnt_n_i` has no effect: `bus_oe_o` stays 0 and `bus_req_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_req_i | input | 1 | Internal access request, held until `acc_done_o` |
| acc_we_i | input | 1 | Access direction, 1 = write |
| acc_addr_i | input | ADDR_W | Access address |
| acc_wdata_i | input | DATA_W | Write data |
| acc_done_o | output | 1 | One-cycle access completion pulse |
| acc_rdata_o | output | DATA_W | Read data, valid with `acc_done_o` on reads |
| bus_req_n_o | output | 1 | Bus mastership request to the master, active low |
| bus_gnt_n_i | input | 1 | Bus grant from the master, active low |
| bus_oe_o | output | 1 | 1 = shared control signals driven, 0 = high impedance |
| bus_own_o | output | 1 | 1 = engine sequences the controls, 0 = controls held inactive |
| eng_start_o | output | 1 | One-cycle start of the engine's bus cycle |
| eng_we_o | output | 1 | Captured direction for the engine |
| eng_addr_o | output | ADDR_W | Captured address for the engine |
| eng_wdata_o | output | DATA_W | Captured write data for the engine |
| eng_done_i | input | 1 | Engine bus cycle complete |
| eng_rdata_i | input | DATA_W | Read data from the engine, valid with `eng_done_i` |

## Verification
Every cycle the assertions check four things. The controls are driven only while the request is low or in the single release cycle. A rise of the output enable follows two granted samples. The start pulse lasts one cycle and comes right after a pre-drive cycle. The controls float on the edge after the release. The exact edge counts need the bench's cycle-accurate model of the requester and the master: the rise of `bus_oe_o` exactly `DRIVE_DELAY` edges after the first granted sample, the restart after grant pulses of one and two cycles, spurious grants while idle having no effect, and one full request per back-to-back access.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ARM  = 3'd2,
        ST_PRE  = 3'd3,
        ST_ACC  = 3'd4,
        ST_REL  = 3'd5
    } bmr_state_e;

    function automatic logic holds_request(input bmr_state_e st);
        return (st == ST_REQ) || (st == ST_ARM) || (st == ST_PRE) || (st == ST_ACC);
    endfunction

    function automatic logic drives_controls(input bmr_state_e st);
        return (st == ST_PRE) || (st == ST_ACC) || (st == ST_REL);
    endfunction

endpackage

// File: rtl/bmr_grant_qual.sv
module bmr_grant_qual #(
    parameter int MIN_GRANT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic gnt_i,
    output logic qualified_o
);
    localparam int CNT_W = $clog2(MIN_GRANT + 1);
    localparam logic [CNT_W-1:0] RUN_SAT  = CNT_W'(MIN_GRANT);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(MIN_GRANT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } qual_t;

    qual_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!enable_i || !gnt_i) begin
            nxt_d.run = '0;
        end else if (cur_q.run != RUN_SAT) begin
            nxt_d.run = cur_q.run + 1'b1;
        end
        qualified_o = enable_i && gnt_i && (cur_q.run >= RUN_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/bmr_wait_timer.sv
module bmr_wait_timer #(
    parameter int SPAN = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic dec_i,
    output logic expired_o
);
    localparam int WAIT_W = $clog2(SPAN + 2);
    localparam logic [WAIT_W-1:0] LOAD_VAL = WAIT_W'(SPAN);

    typedef struct packed {
        logic [WAIT_W-1:0] left;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.left = LOAD_VAL;
        end else if (dec_i && (cur_q.left != '0)) begin
            nxt_d.left = cur_q.left - 1'b1;
        end
        expired_o = (cur_q.left == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/bmr_xfer_regs.sv
module bmr_xfer_regs #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_capture_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } xfer_t;

    xfer_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (capture_i) begin
            nxt_d.we    = we_i;
            nxt_d.addr  = addr_i;
            nxt_d.wdata = wdata_i;
        end
        if (rd_capture_i) begin
            nxt_d.rdata = rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign we_o    = cur_q.we;
    assign addr_o  = cur_q.addr;
    assign wdata_o = cur_q.wdata;
    assign rdata_o = cur_q.rdata;
endmodule

// File: rtl/slave_bus_requester.sv
module slave_bus_requester
    import bmr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int MIN_GRANT   = 2,
    parameter int DRIVE_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req_i,
    input  logic              acc_we_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    output logic              acc_done_o,
    output logic [DATA_W-1:0] acc_rdata_o,
    output logic              bus_req_n_o,
    input  logic              bus_gnt_n_i,
    output logic              bus_oe_o,
    output logic              bus_own_o,
    output logic              eng_start_o,
    output logic              eng_we_o,
    output logic [ADDR_W-1:0] eng_addr_o,
    output logic [DATA_W-1:0] eng_wdata_o,
    input  logic              eng_done_i,
    input  logic [DATA_W-1:0] eng_rdata_i
);
    localparam int WAIT_SPAN = (DRIVE_DELAY > MIN_GRANT) ? (DRIVE_DELAY - MIN_GRANT) : 0;

    typedef struct packed {
        bmr_state_e st;
        logic       req_n;
        logic       oe;
        logic       own;
        logic       start;
        logic       done;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic granted;
    logic qual_en, qualified;
    logic tmr_load, tmr_dec, tmr_expired;
    logic cap_req, cap_rd;

    assign granted = !bus_gnt_n_i;
    assign qual_en = (cur_q.st == ST_REQ);

    bmr_grant_qual #(.MIN_GRANT(MIN_GRANT)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (qual_en),
        .gnt_i      (granted),
        .qualified_o(qualified)
    );

    bmr_wait_timer #(.SPAN(WAIT_SPAN)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .dec_i    (tmr_dec),
        .expired_o(tmr_expired)
    );

    bmr_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (cap_req),
        .we_i        (acc_we_i),
        .addr_i      (acc_addr_i),
        .wdata_i     (acc_wdata_i),
        .rd_capture_i(cap_rd),
        .rdata_i     (eng_rdata_i),
        .we_o        (eng_we_o),
        .addr_o      (eng_addr_o),
        .wdata_o     (eng_wdata_o),
        .rdata_o     (acc_rdata_o)
    );

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        cap_req  = 1'b0;
        cap_rd   = 1'b0;

        unique case (cur_q.st)
            ST_IDLE: begin
                if (acc_req_i) begin
                    nxt_d.st = ST_REQ;
                    cap_req  = 1'b1;
                end
            end
            ST_REQ: begin
                if (qualified) begin
                    nxt_d.st = ST_ARM;
                    tmr_load = 1'b1;
                end
            end
            ST_ARM: begin
                if (!granted) begin
                    nxt_d.st = ST_REQ;
                end else if (tmr_expired) begin
                    nxt_d.st = ST_PRE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_PRE: begin
                nxt_d.st = ST_ACC;
            end
            ST_ACC: begin
                if (eng_done_i) begin
                    nxt_d.st = ST_REL;
                    cap_rd   = !eng_we_o;
                end
            end
            ST_REL: begin
                nxt_d.st = ST_IDLE;
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase

        nxt_d.req_n = !holds_request(nxt_d.st);
        nxt_d.oe    = drives_controls(nxt_d.st);
        nxt_d.own   = (nxt_d.st == ST_ACC);
        nxt_d.start = (nxt_d.st == ST_ACC) && (cur_q.st == ST_PRE);
        nxt_d.done  = (nxt_d.st == ST_REL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.st    <= ST_IDLE;
            cur_q.req_n <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bus_req_n_o = cur_q.req_n;
    assign bus_oe_o    = cur_q.oe;
    assign bus_own_o   = cur_q.own;
    assign eng_start_o = cur_q.start;
    assign acc_done_o  = cur_q.done;
endmodule

// File: rtl/slave_bus_requester_chk.sv
module slave_bus_requester_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_req_n_o,
    input logic bus_gnt_n_i,
    input logic bus_oe_o,
    input logic bus_own_o,
    input logic eng_start_o,
    input logic acc_done_o
);
    // R1: the release state is held throughout reset
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_released_R1: assert (bus_req_n_o && !bus_oe_o && !bus_own_o);
        end
    end

    assert_drive_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (!bus_req_n_o || $past(!bus_req_n_o)));

    assert_drive_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> ($past(!bus_gnt_n_i, 1) && $past(!bus_gnt_n_i, 2) && !bus_own_o));

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |=> !eng_start_o);

    assert_start_after_predrive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own_o) |-> (eng_start_o && $past(bus_oe_o)));

    assert_float_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && bus_req_n_o) |=> !bus_oe_o);

    assert_done_in_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done_o |-> (bus_req_n_o && bus_oe_o && !bus_own_o));

    assert_request_during_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own_o |-> !bus_req_n_o);
endmodule

bind slave_bus_requester slave_bus_requester_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req_n_o(bus_req_n_o),
    .bus_gnt_n_i(bus_gnt_n_i),
    .bus_oe_o   (bus_oe_o),
    .bus_own_o  (bus_own_o),
    .eng_start_o(eng_start_o),
    .acc_done_o (acc_done_o)
);

// File: tb/slave_bus_requester_test.sv
module slave_bus_requester_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int MING = 2;
    localparam int DDLY = 2;
    localparam int N_ACC = 60;
    localparam int MAX_CYC = 30000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic acc_req, acc_we, acc_done;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata, acc_rdata;
    logic breq_n, bgnt_n, oe, own, start, eng_we, eng_done;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_wdata, eng_rdata;

    slave_bus_requester #(.ADDR_W(AW), .DATA_W(DW), .MIN_GRANT(MING), .DRIVE_DELAY(DDLY)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_req_i(acc_req), .acc_we_i(acc_we), .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
        .acc_done_o(acc_done), .acc_rdata_o(acc_rdata),
        .bus_req_n_o(breq_n), .bus_gnt_n_i(bgnt_n), .bus_oe_o(oe), .bus_own_o(own),
        .eng_start_o(start), .eng_we_o(eng_we), .eng_addr_o(eng_addr), .eng_wdata_o(eng_wdata),
        .eng_done_i(eng_done), .eng_rdata_i(eng_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference model: phase 0 idle, 1 requesting, 2 qualified wait, 3 pre-drive, 4 access, 5 release
    int m_ph = 0, m_prev = 0, m_run = 0, m_wait = 0;
    logic m_first = 1'b0, m_we = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0, m_rdata = '0;

    // stimulus state
    logic req_on = 1'b0;
    int gap = 0, n_done = 0, n_req_falls = 0;
    logic g_hold = 1'b0;
    int g_pulse = 0, g_delay = 0;
    logic e_pend = 1'b0;
    int e_lat = 0;
    logic prev_breq_n = 1'b1;

    function automatic string tag_of(input int ph, input int prev);
        if (ph == 1 && prev == 0) return "R2";
        if (ph == 0 && prev == 5) return "R7";
        if (ph == 0) return "R9";
        if (ph == 1 || ph == 2) return "R3";
        if (ph == 3) return "R4";
        if (ph == 4) return "R5";
        return "R6";
    endfunction

    task automatic model_step();
        int nph;
        nph = m_ph;
        case (m_ph)
            0: if (acc_req) begin nph = 1; m_addr = acc_addr; m_we = acc_we; m_wdata = acc_wdata; m_run = 0; end
            1: begin
                if (!bgnt_n) begin
                    m_run++;
                    if (m_run >= MING) begin nph = 2; m_wait = DDLY - MING; end
                end else m_run = 0;
            end
            2: begin
                if (bgnt_n) begin nph = 1; m_run = 0; end
                else if (m_wait == 0) nph = 3;
                else m_wait--;
            end
            3: begin nph = 4; m_first = 1'b1; end
            4: begin
                m_first = 1'b0;
                if (eng_done) begin nph = 5; if (!m_we) m_rdata = eng_rdata; end
            end
            default: nph = 0;
        endcase
        if (m_ph == 3) m_first = 1'b1;
        m_prev = m_ph;
        m_ph = nph;
    endtask

    initial begin
        int cyc;
        rst_n = 1'b0; acc_req = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
        bgnt_n = 1'b1; eng_done = 1'b0; eng_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset breq_n", 64'(breq_n), 64'd1);
        chk("R1", "reset oe", 64'(oe), 64'd0);
        chk("R1", "reset own/start/done", 64'({own, start, acc_done}), 64'd0);
        // a granted line during reset and right after must be ignored (R9)
        bgnt_n = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset breq_n", 64'(breq_n), 64'd1);
        chk("R9", "idle grant ignored oe", 64'(oe), 64'd0);
        bgnt_n = 1'b1;
        @(negedge clk);

        cyc = 0;
        while (n_done < N_ACC && cyc < MAX_CYC) begin
            string tg;
            cyc++;
            // compare outputs produced by the previous edge
            tg = tag_of(m_ph, m_prev);
            chk(tg, "bus_req_n", 64'(breq_n), 64'((m_ph == 0 || m_ph == 5) ? 1 : 0));
            chk(tg, "bus_oe", 64'(oe), 64'((m_ph >= 3) ? 1 : 0));
            chk(tg, "bus_own", 64'(own), 64'((m_ph == 4) ? 1 : 0));
            chk(tg, "eng_start", 64'(start), 64'((m_ph == 4 && m_first) ? 1 : 0));
            chk(tg, "acc_done", 64'(acc_done), 64'((m_ph == 5) ? 1 : 0));
            if (m_ph == 4 && m_first) begin
                chk("R5", "eng_addr", 64'(eng_addr), 64'(m_addr));
                chk("R5", "eng_wdata", 64'(eng_wdata), 64'(m_wdata));
                chk("R5", "eng_we", 64'(eng_we), 64'(m_we));
            end
            if (m_ph == 5 && !m_we) chk("R6", "acc_rdata", 64'(acc_rdata), 64'(m_rdata));
            if (prev_breq_n && !breq_n) n_req_falls++;
            prev_breq_n = breq_n;

            // requester
            if (req_on && acc_done) begin
                req_on = 1'b0; acc_req = 1'b0; n_done++; gap = $urandom % 3;
            end else if (!req_on) begin
                if (gap > 0) gap--;
                else begin
                    req_on = 1'b1; acc_req = 1'b1;
                    acc_addr = $urandom; acc_wdata = $urandom; acc_we = $urandom % 2;
                end
            end

            // master
            if (!breq_n) begin
                if (g_hold) bgnt_n = 1'b0;
                else if (g_pulse > 0) begin
                    g_pulse--;
                    bgnt_n = (g_pulse == 0);
                    if (g_pulse == 0) g_delay = $urandom % 4;
                end else if (g_delay > 0) begin
                    g_delay--; bgnt_n = 1'b1;
                end else if ($urandom % 3 == 0) begin
                    g_pulse = 1 + ($urandom % 2); bgnt_n = 1'b0;
                end else begin
                    g_hold = 1'b1; bgnt_n = 1'b0;
                end
            end else begin
                g_hold = 1'b0; g_pulse = 0; g_delay = $urandom % 4;
                bgnt_n = ($urandom % 6 == 0) ? 1'b0 : 1'b1;
            end

            // engine
            if (start) begin e_pend = 1'b1; e_lat = $urandom % 4; end
            eng_done = 1'b0;
            if (e_pend) begin
                if (e_lat == 0) begin eng_done = 1'b1; eng_rdata = $urandom; e_pend = 1'b0; end
                else e_lat--;
            end

            model_step();
            @(negedge clk);
        end

        if (cyc >= MAX_CYC) begin
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d accesses", n_done, N_ACC);
        end
        chk("R8", "accesses completed", 64'(n_done), 64'(N_ACC));
        chk("R8", "one request per access", 64'(n_req_falls), 64'(N_ACC));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule